// File: doc/BRIEF.md
# GPIO Edge-Interrupt Port

A port of general-purpose pins on a 16-bit register bus. Each pin is an input or an output, chosen by its direction bit. Output pins drive the output register value. Input pins pass through a two-flop synchroniser, and their values can be read back. A rising or falling transition on an input pin, chosen per pin, sets a sticky status bit. Any set status bit raises one interrupt line. Reading the status register returns the pending bits and clears them.

An event mode selects one pin. When that pin changes, the whole synchronised input word is copied into a snapshot latch. Edge detection and the snapshot work only while the functional-clock enable is high. A debounce setting is stored and read back, but it does not filter anything. Register reads are combinational in the cycle of the request, and writes take effect at the clock edge.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, the direction register reads 0xFFFF (all pins are inputs), and `pins_oe_o` is 0. The output, edge-select, mask, event, status and snapshot registers all read 0, and `irq_o` is low.
- R2: Writes to offsets 0x04 (output), 0x08 (direction), 0x1C (edge select) and 0x2C (mask) store all 16 bits. Offset 0x18 (event) keeps only bits 4:0, and offset 0x30 (debounce) keeps only bits 8:0. The upper bits of both read back as 0.
- R3: `pins_oe_o` equals the inverse of the direction register, and `pins_o` equals output AND NOT direction. A write to either register shows on these pins in the cycle after the write.
- R4: Offset 0x00 returns the pin inputs through two flops. A change on `pins_i` is visible after two rising clock edges and not after one.
- R5: If a pin is an input, unmasked, and has edge-select bit 1, a 0-to-1 transition sets its status bit (offset 0x24), and `irq_o` stays high while any status bit is set.
- R6: If a pin is an input, unmasked, and has edge-select bit 0, a 1-to-0 transition sets its status bit. A rising transition on that pin does not.
- R7: A pin whose mask bit (offset 0x2C) is 1, or whose direction bit is 0, never sets its status bit.
- R8: While `fclk_en_i` is low, no transition sets a status bit or loads the snapshot. Transitions made while it is low are not reported once it goes high again.
- R9: A read of offset 0x24 returns the pending bits and clears them, so `irq_o` falls in the following cycle.
- R10: Event register bit 0 enables the snapshot, and bits 4:1 select the pin. A change of the selected pin copies all 16 inputs into offset 0x34. A change on any other pin, or any change while bit 0 is 0, leaves offset 0x34 unchanged.
- R11: Writes to the read-only offsets 0x00, 0x24 and 0x34 have no effect. Writes to unknown offsets have no effect, and reads of unknown offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fclk_en_i | input | 1 | Functional-clock enable; gates edge detection and the snapshot |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| pins_i | input | 16 | Pin input levels |
| pins_o | output | 16 | Pin output levels |
| pins_oe_o | output | 16 | Pin output enables |
| irq_o | output | 1 | Interrupt, high while any status bit is set |

## Verification
A wrong synchroniser depth or a wrong edge history shows up at offset 0x00 one cycle early or late. It also shows up as a status bit that is missing or extra within three cycles of a pin change. A status register that is not cleared, or is cleared at the wrong time, leaves `irq_o` high in the cycle after the read. A wrong selector decode or a wrong gate for the event snapshot appears only when offset 0x34 is read back. For that reason the snapshot is read after triggering changes and after non-triggering changes.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_IN    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_OUT   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_DIR   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_EVT   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_EDGE  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_DBNC  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_SNAP  = 8'h34;

  function automatic logic is_known(input logic [ADDR_W-1:0] a);
    return a inside {OFF_IN, OFF_OUT, OFF_DIR, OFF_EVT, OFF_EDGE,
                     OFF_STAT, OFF_MASK, OFF_DBNC, OFF_SNAP};
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
  parameter int N     = 16,
  parameter int SEL_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fclk_en_i,
  input  logic [N-1:0]     sync_i,
  input  logic [N-1:0]     dir_i,
  input  logic [N-1:0]     mask_i,
  input  logic [N-1:0]     rise_sel_i,
  input  logic             evt_en_i,
  input  logic [SEL_W-1:0] evt_sel_i,
  output logic [N-1:0]     hit_o,
  output logic             snap_load_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] chg;

  // history always tracks, so gated-off transitions are never replayed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  assign chg = sync_i ^ prev_q;

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic pol_ok;
    assign pol_ok   = rise_sel_i[g] ? sync_i[g] : ~sync_i[g];
    assign hit_o[g] = fclk_en_i & dir_i[g] & ~mask_i[g] & chg[g] & pol_ok;
  end

  assign snap_load_o = fclk_en_i & evt_en_i & chg[evt_sel_i];
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DBNC_W   = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fclk_en_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] pins_o,
  output logic [NUM_PINS-1:0] pins_oe_o,
  output logic                irq_o
);
  localparam int SEL_W = $clog2(NUM_PINS);
  localparam int EVT_W = SEL_W + 1;

  logic [NUM_PINS-1:0] out_q, dir_q, edge_q, mask_q, stat_q, snap_q;
  logic [EVT_W-1:0]    evt_q;
  logic [DBNC_W-1:0]   dbnc_q;
  logic [NUM_PINS-1:0] sync_val, hit;
  logic                snap_load, wr, rd_stat;

  gpio_sync #(.W(NUM_PINS), .STAGES(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (sync_val)
  );

  gpio_edge_unit #(.N(NUM_PINS), .SEL_W(SEL_W)) i_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fclk_en_i  (fclk_en_i),
    .sync_i     (sync_val),
    .dir_i      (dir_q),
    .mask_i     (mask_q),
    .rise_sel_i (edge_q),
    .evt_en_i   (evt_q[0]),
    .evt_sel_i  (evt_q[EVT_W-1:1]),
    .hit_o      (hit),
    .snap_load_o(snap_load)
  );

  assign wr      = req_i & we_i;
  assign rd_stat = req_i & ~we_i & (addr_i == OFF_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '1;
      edge_q <= '0;
      mask_q <= '0;
      evt_q  <= '0;
      dbnc_q <= '0;
    end else if (wr) begin
      unique case (addr_i)
        OFF_OUT:  out_q  <= wdata_i;
        OFF_DIR:  dir_q  <= wdata_i;
        OFF_EDGE: edge_q <= wdata_i;
        OFF_MASK: mask_q <= wdata_i;
        OFF_EVT:  evt_q  <= wdata_i[EVT_W-1:0];
        OFF_DBNC: dbnc_q <= wdata_i[DBNC_W-1:0];
        default: ;
      endcase
    end
  end

  // read-to-clear keeps hits arriving in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      snap_q <= '0;
    end else begin
      stat_q <= rd_stat ? hit : (stat_q | hit);
      if (snap_load) snap_q <= sync_val;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_IN:   rdata_o = sync_val;
      OFF_OUT:  rdata_o = out_q;
      OFF_DIR:  rdata_o = dir_q;
      OFF_EDGE: rdata_o = edge_q;
      OFF_MASK: rdata_o = mask_q;
      OFF_STAT: rdata_o = stat_q;
      OFF_SNAP: rdata_o = snap_q;
      OFF_EVT:  rdata_o[EVT_W-1:0]  = evt_q;
      OFF_DBNC: rdata_o[DBNC_W-1:0] = dbnc_q;
      default: ;
    endcase
  end

  assign pins_oe_o = ~dir_q;
  assign pins_o    = out_q & ~dir_q;
  assign irq_o     = |stat_q;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                fclk_en_i,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [NUM_PINS-1:0] rdata_o,
  input logic [NUM_PINS-1:0] pins_o,
  input logic [NUM_PINS-1:0] pins_oe_o,
  input logic                irq_o
);
  logic rd, rd_stat;
  assign rd      = req_i & ~we_i;
  assign rd_stat = rd & (addr_i == OFF_STAT);

  p_drive_only_oe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_o & ~pins_oe_o) == '0);

  p_evt_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == OFF_EVT) |-> rdata_o[NUM_PINS-1:5] == '0);

  p_dbnc_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == OFF_DBNC) |-> rdata_o[NUM_PINS-1:9] == '0);

  p_irq_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_stat) |=> irq_o);

  p_gated_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fclk_en_i && !irq_o) |=> !irq_o);

  p_read_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && !fclk_en_i) |=> !irq_o);

  p_unknown_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_known(addr_i)) |-> rdata_o == '0);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NUM_PINS(NUM_PINS)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .fclk_en_i(fclk_en_i),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .pins_o   (pins_o),
  .pins_oe_o(pins_oe_o),
  .irq_o    (irq_o)
);

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fclk_en = 1'b1;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0, rdata, pins_in = '0, pins_out, pins_oe;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  gpio_edge_port i_gpio_edge_port (
    .clk_i(clk), .rst_ni(rst_n), .fclk_en_i(fclk_en),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pins_i(pins_in), .pins_o(pins_out), .pins_oe_o(pins_oe), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk); pins_in = v; idle(4);
  endtask

  task automatic clear_stat();
    logic [15:0] d;
    rd(8'h24, d);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 irq", {15'd0, irq}, 16'h0);
    chk("R1 oe", pins_oe, 16'h0);
    rd(8'h08, d); chk("R1 dir", d, 16'hFFFF);
    rd(8'h04, d); chk("R1 out", d, 16'h0);
    rd(8'h1C, d); chk("R1 edge", d, 16'h0);
    rd(8'h2C, d); chk("R1 mask", d, 16'h0);
    rd(8'h18, d); chk("R1 evt", d, 16'h0);
    rd(8'h24, d); chk("R1 stat", d, 16'h0);
    rd(8'h34, d); chk("R1 snap", d, 16'h0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(8'h18, 16'hFFFF); rd(8'h18, d); chk("R2 evt width", d, 16'h001F);
    wr(8'h30, 16'hFFFF); rd(8'h30, d); chk("R2 dbnc width", d, 16'h01FF);
    wr(8'h1C, 16'hA5A5); rd(8'h1C, d); chk("R2 edge", d, 16'hA5A5);
    wr(8'h2C, 16'h5A5A); rd(8'h2C, d); chk("R2 mask", d, 16'h5A5A);
    wr(8'h18, 16'h0); wr(8'h1C, 16'h0); wr(8'h2C, 16'h0);
  endtask

  task automatic t_dir();
    wr(8'h08, 16'hFF00); wr(8'h04, 16'h1234);
    chk("R3 pins_o", pins_out, 16'h0034);
    chk("R3 oe", pins_oe, 16'h00FF);
    wr(8'h08, 16'hFFF0);
    chk("R3 pins_o after dir", pins_out, 16'h0004);
    chk("R3 oe after dir", pins_oe, 16'h000F);
    wr(8'h08, 16'hFFFF); wr(8'h04, 16'h0);
  endtask

  task automatic t_sync();
    @(negedge clk); pins_in = 16'h0F0F; req = 1; we = 0; addr = 8'h00;
    @(negedge clk); chk("R4 after one edge", rdata, 16'h0000);
    @(negedge clk); chk("R4 after two edges", rdata, 16'h0F0F);
    req = 0;
    pins_in = 16'h0000; idle(4);
    wr(8'h2C, 16'h0); clear_stat();
  endtask

  task automatic t_rise();
    logic [15:0] d;
    wr(8'h1C, 16'h0001);
    set_pins(16'h0001);
    chk("R5 irq", {15'd0, irq}, 16'h1);
    rd(8'h24, d); chk("R5 stat rise", d, 16'h0001);
    chk("R9 irq cleared", {15'd0, irq}, 16'h0);
    rd(8'h24, d); chk("R9 stat cleared", d, 16'h0000);
  endtask

  task automatic t_fall();
    logic [15:0] d;
    wr(8'h1C, 16'h0000);
    set_pins(16'h0011);
    rd(8'h24, d); chk("R6 rise ignored", d, 16'h0000);
    set_pins(16'h0000);
    rd(8'h24, d); chk("R6 stat fall", d, 16'h0011);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wr(8'h1C, 16'h0006); wr(8'h2C, 16'h0002); wr(8'h08, 16'hFFFB);
    set_pins(16'h0006);
    rd(8'h24, d); chk("R7 masked/output", d, 16'h0000);
    chk("R7 irq", {15'd0, irq}, 16'h0);
    wr(8'h2C, 16'h0); wr(8'h08, 16'hFFFF); wr(8'h1C, 16'h0);
    set_pins(16'h0000); clear_stat();
  endtask

  task automatic t_gate();
    logic [15:0] d;
    wr(8'h1C, 16'hFFFF); wr(8'h18, 16'h0001);
    @(negedge clk); fclk_en = 0;
    set_pins(16'h0003);
    rd(8'h24, d); chk("R8 gated stat", d, 16'h0000);
    rd(8'h34, d); chk("R8 gated snap", d, 16'h0000);
    @(negedge clk); fclk_en = 1; idle(3);
    rd(8'h24, d); chk("R8 no replay", d, 16'h0000);
    wr(8'h18, 16'h0); wr(8'h1C, 16'h0);
    set_pins(16'h0000); clear_stat();
  endtask

  task automatic t_event();
    logic [15:0] d;
    wr(8'h18, 16'h0007);             // enable, pin 3
    set_pins(16'h5A08);
    rd(8'h34, d); chk("R10 snapshot", d, 16'h5A08);
    set_pins(16'h5A0C);
    rd(8'h34, d); chk("R10 other pin", d, 16'h5A08);
    wr(8'h18, 16'h0006);             // disabled, pin 3
    set_pins(16'h5A04);
    rd(8'h34, d); chk("R10 disabled", d, 16'h5A08);
    wr(8'h18, 16'h0);
    set_pins(16'h0000); clear_stat();
  endtask

  task automatic t_readonly();
    logic [15:0] d;
    set_pins(16'h00C3);
    wr(8'h00, 16'hFFFF); rd(8'h00, d); chk("R11 input ro", d, 16'h00C3);
    wr(8'h34, 16'hFFFF); rd(8'h34, d); chk("R11 snap ro", d, 16'h5A08);
    clear_stat();
    wr(8'h24, 16'hFFFF); rd(8'h24, d); chk("R11 stat ro", d, 16'h0000);
    chk("R11 irq", {15'd0, irq}, 16'h0);
    wr(8'h0C, 16'h1234); rd(8'h0C, d); chk("R11 unknown read", d, 16'h0000);
    rd(8'h08, d); chk("R11 dir untouched", d, 16'hFFFF);
    rd(8'h04, d); chk("R11 out untouched", d, 16'h0000);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(2);
    t_reset();
    t_regs();
    t_dir();
    t_sync();
    t_rise();
    t_fall();
    t_mask();
    t_gate();
    t_event();
    t_readonly();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule